// File: doc/BRIEF.md
# SMBus Controller Flag Register Logic

This block keeps the eight status and control flags that a two-wire serial bus controller exposes to software. The flags cover master mode, transmit direction, a received-start marker, a stop marker, a pending acknowledge response, lost arbitration, the last acknowledge bit seen and the serial interrupt flag. A separate bus engine handles the wires, timing and address matching. It reports what happened on the bus as single-cycle event strobes. Software reaches the block through a flag-vector write strobe and a strobe that marks a write of the data register.

On every clock each flag follows a fixed order. A hardware set beats a hardware clear. A hardware clear beats a software write. With no event and no write the flag keeps its value. Some flags can only be cleared by software. Writing the data register before a frame begins decides whether the controller transmits in that frame. The interrupt request is registered: it is the new interrupt flag gated by an enable input.

Top module: `smb_flag_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears all eight flags and `irq` at the next clock edge.
- R2: `flags` bit positions: 0 master, 1 transmit, 2 start-seen, 3 stop-seen, 4 ack-request, 5 arbitration-lost, 6 ack, 7 interrupt. A `sw_wr` loads only bits 2, 3, 6 and 7 from `sw_wdata`. Bits 0, 1, 4 and 5 ignore it.
- R3: The master bit sets on `ev_start_gen`. It clears on `ev_stop_gen` or `ev_arb_lost`.
- R4: The transmit bit sets on `ev_start_gen`. It clears on `ev_start_det` or `ev_arb_lost`.
- R5: `sw_dat_wr` marks the data register as written, and the mark lasts until the next `ev_frm_start`. On `ev_frm_start` the transmit bit sets if the mark is present or `sw_dat_wr` is high in that cycle, and clears otherwise. The frame start consumes the mark.
- R6: The start-seen bit sets on `ev_start_addr`. Only a software write of 0 clears it.
- R7: The stop-seen bit sets on `ev_stop_det` while `slv_addr` is high, or on `ev_arb_lost` while `arb_cause_stop` is high. It clears on `ev_stop_gen`.
- R8: The ack-request bit sets on `ev_byte_rx` and clears on `ev_ack_done`.
- R9: On `ev_ack_rx` the ack bit becomes the inverse of `ack_lvl`: a low level sets it and a high level clears it.
- R10: The interrupt bit sets on any of these: `ev_start_gen`, `ev_arb_lost`, `ev_ack_rx`, `ev_byte_rx`, `ev_start_addr`, or `ev_stop_det` while `slv_addr` is high. Only a software write of 0 clears it.
- R11: The arbitration-lost bit sets on `ev_arb_lost`. It clears whenever `sw_wr` is high with `sw_wdata[7]` low.
- R12: Within one cycle a hardware set beats a hardware clear, and a hardware clear beats a software write.
- R13: After each edge, `irq` equals the interrupt bit AND the value `irq_en` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_gen | input | 1 | Controller generated a START |
| ev_stop_gen | input | 1 | Controller generated a STOP |
| ev_start_det | input | 1 | A START was detected on the bus |
| ev_start_addr | input | 1 | START plus address byte received |
| ev_stop_det | input | 1 | A STOP was detected on the bus |
| slv_addr | input | 1 | Level: controller is addressed as a slave |
| ev_arb_lost | input | 1 | Arbitration lost |
| arb_cause_stop | input | 1 | Qualifier: the lost arbitration came from a detected STOP |
| ev_byte_rx | input | 1 | A byte was received |
| ev_ack_done | input | 1 | An ACK cycle finished |
| ev_ack_rx | input | 1 | A byte was sent and its ACK bit was sampled |
| ack_lvl | input | 1 | Sampled ACK line level, valid with ev_ack_rx |
| ev_frm_start | input | 1 | A bus frame begins |
| sw_wr | input | 1 | Software write of the flag vector |
| sw_wdata | input | 8 | Flag value written by software |
| sw_dat_wr | input | 1 | Software wrote the data register |
| irq_en | input | 1 | Interrupt enable |
| flags | output | 8 | Registered flag vector |
| irq | output | 1 | Registered interrupt request |

## Verification
The interesting collisions are a hardware event and a software write reaching the same flag in one cycle. Examples are a byte arriving while software clears the interrupt bit, and a start-plus-address event while software clears the start-seen bit. A second case is a data-register write in the same cycle as a frame start. Directed cycles force each of these collisions. Long random runs also raise every strobe and `sw_wr` at a fair rate, so collisions happen often. A behavioural model applies the software write first, then the hardware clears, then the hardware sets, and it judges every output on every cycle.

// File: rtl/smb_flag_pkg.sv
`timescale 1ns/1ps
package smb_flag_pkg;
  localparam int NFLAG = 8;
  localparam int F_MST = 0;
  localparam int F_TXM = 1;
  localparam int F_STR = 2;
  localparam int F_STP = 3;
  localparam int F_AKR = 4;
  localparam int F_ARB = 5;
  localparam int F_ACK = 6;
  localparam int F_IRQ = 7;
  // bits that software may load: start-seen, stop-seen, ack, interrupt
  localparam logic [NFLAG-1:0] SW_WMASK = 8'b1100_1100;
endpackage

// File: rtl/smb_flag_cell.sv
`timescale 1ns/1ps
module smb_flag_cell #(
  parameter bit SW_WRITABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_bit,
  output logic d_nxt,
  output logic q
);
  // priority: hardware set, hardware clear, software load, hold
  always_comb begin
    if (hw_set)                   d_nxt = 1'b1;
    else if (hw_clr)              d_nxt = 1'b0;
    else if (SW_WRITABLE && sw_we) d_nxt = sw_bit;
    else                          d_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_nxt;
  end
endmodule

// File: rtl/smb_flag_evdec.sv
`timescale 1ns/1ps
module smb_flag_evdec
  import smb_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_start_gen,
  input  logic             ev_stop_gen,
  input  logic             ev_start_det,
  input  logic             ev_start_addr,
  input  logic             ev_stop_det,
  input  logic             slv_addr,
  input  logic             ev_arb_lost,
  input  logic             arb_cause_stop,
  input  logic             ev_byte_rx,
  input  logic             ev_ack_done,
  input  logic             ev_ack_rx,
  input  logic             ack_lvl,
  input  logic             ev_frm_start,
  input  logic             sw_wr,
  input  logic             sw_irq_bit,
  input  logic             sw_dat_wr,
  output logic [NFLAG-1:0] set_v,
  output logic [NFLAG-1:0] clr_v
);
  logic dat_pend;
  logic dat_now;
  logic stop_as_slave;

  // mark: data register written since the last frame start
  always_ff @(posedge clk) begin
    if (rst)               dat_pend <= 1'b0;
    else if (ev_frm_start) dat_pend <= 1'b0;
    else if (sw_dat_wr)    dat_pend <= 1'b1;
  end

  assign dat_now       = dat_pend | sw_dat_wr;
  assign stop_as_slave = ev_stop_det & slv_addr;

  always_comb begin
    set_v = '0;
    clr_v = '0;

    set_v[F_MST] = ev_start_gen;
    clr_v[F_MST] = ev_stop_gen | ev_arb_lost;

    set_v[F_TXM] = ev_start_gen | (ev_frm_start & dat_now);
    clr_v[F_TXM] = ev_start_det | ev_arb_lost | (ev_frm_start & ~dat_now);

    set_v[F_STR] = ev_start_addr;

    set_v[F_STP] = stop_as_slave | (ev_arb_lost & arb_cause_stop);
    clr_v[F_STP] = ev_stop_gen;

    set_v[F_AKR] = ev_byte_rx;
    clr_v[F_AKR] = ev_ack_done;

    set_v[F_ARB] = ev_arb_lost;
    clr_v[F_ARB] = sw_wr & ~sw_irq_bit;

    set_v[F_ACK] = ev_ack_rx & ~ack_lvl;
    clr_v[F_ACK] = ev_ack_rx & ack_lvl;

    set_v[F_IRQ] = ev_start_gen | ev_arb_lost | ev_ack_rx | ev_byte_rx
                 | ev_start_addr | stop_as_slave;
  end
endmodule

// File: rtl/smb_flag_ctrl.sv
`timescale 1ns/1ps
module smb_flag_ctrl
  import smb_flag_pkg::*;
#(
  parameter int FLAG_W = NFLAG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start_gen,
  input  logic              ev_stop_gen,
  input  logic              ev_start_det,
  input  logic              ev_start_addr,
  input  logic              ev_stop_det,
  input  logic              slv_addr,
  input  logic              ev_arb_lost,
  input  logic              arb_cause_stop,
  input  logic              ev_byte_rx,
  input  logic              ev_ack_done,
  input  logic              ev_ack_rx,
  input  logic              ack_lvl,
  input  logic              ev_frm_start,
  input  logic              sw_wr,
  input  logic [FLAG_W-1:0] sw_wdata,
  input  logic              sw_dat_wr,
  input  logic              irq_en,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] nxt_v;

  smb_flag_evdec u_dec (
    .clk            (clk),
    .rst            (rst),
    .ev_start_gen   (ev_start_gen),
    .ev_stop_gen    (ev_stop_gen),
    .ev_start_det   (ev_start_det),
    .ev_start_addr  (ev_start_addr),
    .ev_stop_det    (ev_stop_det),
    .slv_addr       (slv_addr),
    .ev_arb_lost    (ev_arb_lost),
    .arb_cause_stop (arb_cause_stop),
    .ev_byte_rx     (ev_byte_rx),
    .ev_ack_done    (ev_ack_done),
    .ev_ack_rx      (ev_ack_rx),
    .ack_lvl        (ack_lvl),
    .ev_frm_start   (ev_frm_start),
    .sw_wr          (sw_wr),
    .sw_irq_bit     (sw_wdata[F_IRQ]),
    .sw_dat_wr      (sw_dat_wr),
    .set_v          (set_v),
    .clr_v          (clr_v)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    smb_flag_cell #(.SW_WRITABLE(SW_WMASK[i])) u_cell (
      .clk    (clk),
      .rst    (rst),
      .hw_set (set_v[i]),
      .hw_clr (clr_v[i]),
      .sw_we  (sw_wr),
      .sw_bit (sw_wdata[i]),
      .d_nxt  (nxt_v[i]),
      .q      (flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= nxt_v[F_IRQ] & irq_en;
  end
endmodule

// File: rtl/smb_flag_chk.sv
`timescale 1ns/1ps
module smb_flag_chk
  import smb_flag_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ev_start_gen,
  input logic             ev_stop_gen,
  input logic             ev_arb_lost,
  input logic             ev_byte_rx,
  input logic             ev_ack_rx,
  input logic             ack_lvl,
  input logic             sw_wr,
  input logic [NFLAG-1:0] sw_wdata,
  input logic             irq_en,
  input logic [NFLAG-1:0] flags,
  input logic             irq
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flags == '0 && !irq));

  a_r3_mst_set: assert property (@(posedge clk) disable iff (rst)
    ev_start_gen |=> flags[F_MST]);

  a_r2_mst_ro: assert property (@(posedge clk) disable iff (rst)
    (!ev_start_gen && !ev_stop_gen && !ev_arb_lost) |=> $stable(flags[F_MST]));

  a_r11_arb_set: assert property (@(posedge clk) disable iff (rst)
    (ev_arb_lost && !ev_start_gen) |=> (flags[F_ARB] && !flags[F_MST]));

  a_r8_akr_set: assert property (@(posedge clk) disable iff (rst)
    ev_byte_rx |=> flags[F_AKR]);

  a_r9_ack_follow: assert property (@(posedge clk) disable iff (rst)
    ev_ack_rx |=> (flags[F_ACK] == !$past(ack_lvl)));

  a_r6_str_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[F_STR] && !(sw_wr && !sw_wdata[F_STR])) |=> flags[F_STR]);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[F_IRQ] && !(sw_wr && !sw_wdata[F_IRQ])) |=> flags[F_IRQ]);

  a_r13_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  a_r13_irq_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flags[F_IRQ]);
endmodule

bind smb_flag_ctrl smb_flag_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_start_gen (ev_start_gen),
  .ev_stop_gen  (ev_stop_gen),
  .ev_arb_lost  (ev_arb_lost),
  .ev_byte_rx   (ev_byte_rx),
  .ev_ack_rx    (ev_ack_rx),
  .ack_lvl      (ack_lvl),
  .sw_wr        (sw_wr),
  .sw_wdata     (sw_wdata),
  .irq_en       (irq_en),
  .flags        (flags),
  .irq          (irq)
);

// File: tb/tb_smb_flag_ctrl.sv
`timescale 1ns/1ps
module tb_smb_flag_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start_gen = 0, ev_stop_gen = 0, ev_start_det = 0, ev_start_addr = 0;
  logic ev_stop_det = 0, slv_addr = 0, ev_arb_lost = 0, arb_cause_stop = 0;
  logic ev_byte_rx = 0, ev_ack_done = 0, ev_ack_rx = 0, ack_lvl = 0;
  logic ev_frm_start = 0, sw_wr = 0, sw_dat_wr = 0, irq_en = 0;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] flags;
  logic       irq;

  always #10 clk = ~clk;

  smb_flag_ctrl dut (
    .clk(clk), .rst(rst), .ev_start_gen(ev_start_gen), .ev_stop_gen(ev_stop_gen),
    .ev_start_det(ev_start_det), .ev_start_addr(ev_start_addr), .ev_stop_det(ev_stop_det),
    .slv_addr(slv_addr), .ev_arb_lost(ev_arb_lost), .arb_cause_stop(arb_cause_stop),
    .ev_byte_rx(ev_byte_rx), .ev_ack_done(ev_ack_done), .ev_ack_rx(ev_ack_rx),
    .ack_lvl(ack_lvl), .ev_frm_start(ev_frm_start), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_dat_wr(sw_dat_wr), .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit m[8];
  bit m_irq;
  bit m_dw;
  string tag[8] = '{"R3", "R4", "R6", "R7", "R8", "R11", "R9", "R10"};

  task automatic chk(string t, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 8; i++) chk(tag[i], int'(flags[i]), int'(m[i]));
    chk("R13", int'(irq), int'(m_irq));
  endtask

  // behavioural model: software load, then hardware clears, then hardware sets
  task automatic model_step();
    bit nx[8];
    bit wn;
    if (rst) begin
      foreach (m[i]) m[i] = 0;
      m_irq = 0;
      m_dw = 0;
      return;
    end
    nx = m;
    wn = m_dw || sw_dat_wr;
    if (sw_wr) begin
      nx[2] = sw_wdata[2]; nx[3] = sw_wdata[3];
      nx[6] = sw_wdata[6]; nx[7] = sw_wdata[7];
      if (!sw_wdata[7]) nx[5] = 0;
    end
    if (ev_stop_gen || ev_arb_lost) nx[0] = 0;
    if (ev_start_det || ev_arb_lost || (ev_frm_start && !wn)) nx[1] = 0;
    if (ev_stop_gen) nx[3] = 0;
    if (ev_ack_done) nx[4] = 0;
    if (ev_ack_rx && ack_lvl) nx[6] = 0;
    if (ev_start_gen) begin nx[0] = 1; nx[1] = 1; nx[7] = 1; end
    if (ev_frm_start && wn) nx[1] = 1;
    if (ev_start_addr) begin nx[2] = 1; nx[7] = 1; end
    if ((ev_stop_det && slv_addr) || (ev_arb_lost && arb_cause_stop)) nx[3] = 1;
    if (ev_stop_det && slv_addr) nx[7] = 1;
    if (ev_byte_rx) begin nx[4] = 1; nx[7] = 1; end
    if (ev_arb_lost) begin nx[5] = 1; nx[7] = 1; end
    if (ev_ack_rx && !ack_lvl) nx[6] = 1;
    if (ev_ack_rx) nx[7] = 1;
    if (ev_frm_start) m_dw = 0;
    else if (sw_dat_wr) m_dw = 1;
    m = nx;
    m_irq = nx[7] & irq_en;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    {ev_start_gen, ev_stop_gen, ev_start_det, ev_start_addr, ev_stop_det,
     ev_arb_lost, ev_byte_rx, ev_ack_done, ev_ack_rx, ev_frm_start,
     sw_wr, sw_dat_wr} = '0;
  endtask

  task automatic randomize_inputs();
    ev_start_gen   = ($urandom_range(9) == 0);
    ev_stop_gen    = ($urandom_range(9) == 0);
    ev_start_det   = ($urandom_range(9) == 0);
    ev_start_addr  = ($urandom_range(9) == 0);
    ev_stop_det    = ($urandom_range(9) == 0);
    slv_addr       = $urandom_range(1);
    ev_arb_lost    = ($urandom_range(11) == 0);
    arb_cause_stop = $urandom_range(1);
    ev_byte_rx     = ($urandom_range(7) == 0);
    ev_ack_done    = ($urandom_range(7) == 0);
    ev_ack_rx      = ($urandom_range(7) == 0);
    ack_lvl        = $urandom_range(1);
    ev_frm_start   = ($urandom_range(9) == 0);
    sw_wr          = ($urandom_range(5) == 0);
    sw_wdata       = 8'($urandom);
    sw_dat_wr      = ($urandom_range(7) == 0);
    irq_en         = ($urandom_range(3) != 0);
    rst            = ($urandom_range(299) == 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset
    rst = 1;
    cycle();
    cycle();
    chk("R1", int'(flags), 0);
    chk("R1", int'(irq), 0);
    rst = 0;
    irq_en = 1;

    // R2: a write of all ones touches only the writable bits
    idle(); sw_wr = 1; sw_wdata = 8'hFF; cycle();
    chk("R2", int'(flags), 8'hCC);

    // R5: data written before the frame -> transmit; not written -> receive
    idle(); sw_dat_wr = 1; cycle();
    idle(); cycle();
    idle(); ev_frm_start = 1; cycle();
    chk("R5", int'(flags[1]), 1);
    idle(); ev_frm_start = 1; cycle();
    chk("R5", int'(flags[1]), 0);
    idle(); ev_frm_start = 1; sw_dat_wr = 1; cycle();
    chk("R5", int'(flags[1]), 1);

    // R12: hardware set beats software clear in the same cycle
    idle(); sw_wr = 1; sw_wdata = 8'h00; cycle();
    chk("R10", int'(flags[7]), 0);
    idle(); sw_wr = 1; sw_wdata = 8'h00; ev_byte_rx = 1; ev_start_addr = 1; cycle();
    chk("R12", int'(flags[7]), 1);
    chk("R12", int'(flags[2]), 1);
    // R12: hardware clear beats software set
    idle(); sw_wr = 1; sw_wdata = 8'h08; ev_stop_gen = 1; cycle();
    chk("R12", int'(flags[3]), 0);

    // R11: the arbitration-lost bit is cleared by software clearing the interrupt bit
    idle(); ev_arb_lost = 1; arb_cause_stop = 1; cycle();
    chk("R11", int'(flags[5]), 1);
    chk("R7", int'(flags[3]), 1);
    idle(); sw_wr = 1; sw_wdata = 8'h80; cycle();
    chk("R11", int'(flags[5]), 1);
    idle(); sw_wr = 1; sw_wdata = 8'h00; cycle();
    chk("R11", int'(flags[5]), 0);

    // R13: the enable gates the request
    idle(); ev_byte_rx = 1; irq_en = 0; cycle();
    chk("R13", int'(irq), 0);
    idle(); irq_en = 1; cycle();
    chk("R13", int'(irq), 1);

    // random traffic with collisions, compared on every clock
    for (int k = 0; k < 4000; k++) begin
      randomize_inputs();
      cycle();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule